// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes 28 asynchronous external interrupt lines and turns them into four level interrupt requests for a downstream interrupt controller. Each line first goes through a two-flop synchronizer. A per-line detector then watches for the trigger condition selected for that line: low level, high level, falling edge, rising edge or either edge. A detected condition latches into a pending bit. Software clears a pending bit by writing a one to it.

Each line also has a mask bit. A set mask bit keeps the line out of its group output, but the line's pending bit is still latched and can still be read. The 28 lines fall into four groups of unequal size: lines 0–3, 4–11, 12–19 and 20–27. A group output is high while any unmasked pending bit in its group is set.

Software reaches four 32-bit registers through a flat register port. The port has a 2-bit select, a write strobe and a combinational read path. Two of the registers hold the trigger settings. In these, two neighbouring lines share one 3-bit field, and the fields sit on a 4-bit stride.

Top module: `ext_irq_grouped`

## Requirements
- R1: During and directly after reset, all trigger fields read 0 and the pending register reads 0. The mask register reads 0x0FFFFFFF, so every line is masked. All four group outputs are low.
- R2: Register select 0 holds the trigger fields of lines 0–15 and select 1 holds those of lines 16–27. Line n uses the 3-bit field at bit 4*floor(m/2), where m is n for select 0 and n−16 for select 1. Lines 2k and 2k+1 share one field. Bit 3 of every nibble ignores writes and reads 0.
- R3: The field codes are: 000 low level, 001 high level, 010 falling edge, 100 rising edge, 110 or 111 either edge. Codes 011 and 101 disable the line, so it never sets its pending bit.
- R4: In a level mode, the pending bit is set again on every cycle that the synchronized level is active. A clear written while the level is still active has no lasting effect.
- R5: In an edge mode, only the selected transition sets the pending bit. The opposite transition does not. The bit stays set until it is cleared.
- R6: Select 2 is the mask register. A 1 in bit n stops line n from reaching its group output, and a 0 lets it through. The pending bit of a masked line still latches and still reads back at select 3.
- R7: Select 3 is the pending register. Writing a 1 to bit n clears pending bit n. Writing a 0 leaves the bit as it is.
- R8: Group output g is high exactly while some bit of (pending AND NOT mask) is set in its range. The ranges are g0 = lines 0–3, g1 = lines 4–11, g2 = lines 12–19 and g3 = lines 20–27.
- R9: No state exists for line positions above 27. Bits 31:24 of select 1 and bits 31:28 of selects 2 and 3 read 0, and writes to them change nothing.
- R10: A change on a raw input reaches its pending bit on the third rising clock edge after the change. The first two edges fill the synchronizer, and detection happens at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extLines | input | 28 | Raw asynchronous interrupt inputs |
| regSel | input | 2 | Register select: 0/1 trigger fields, 2 mask, 3 pending |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data of the selected register |
| grpIrq | output | 4 | Group interrupt requests, bit g for group g |

## Verification
The bench checks that both lines of a shared field respond together, and that a line near a group border drives the correct group: line 11 drives g1, line 3 drives g0, and line 19 drives g2. A wrong field offset or group range would show up as a pending bit or group output in the wrong position. Level mode is tested by writing a clear while the input is still held active; a design that let a clear win over a live level would read the bit back as zero. Edge modes are driven through both transitions, and the disabled codes are toggled too, which exposes a decoder that swaps polarities or treats 011 as a valid mode. The latency check samples pending after each of the first three edges, so an extra or missing synchronizer stage shows up. Writes to the bits above line 27, and to bit 3 of each nibble, must read back as zero.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int NUM_LINES  = 28;
  localparam int NUM_GROUPS = 4;
  localparam int FIRST_GRP  = 4;
  localparam int GRP_W      = 8;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 3;
  localparam int STRIDE     = 4;
  localparam int NUM_PAIRS  = (NUM_LINES + 1) / 2;
  localparam int PAIRS_PER_REG = DATA_W / STRIDE;

  typedef enum logic [2:0] {
    TRIG_OFF, TRIG_LOW, TRIG_HIGH, TRIG_FALL, TRIG_RISE, TRIG_BOTH
  } trigKind_t;

  typedef struct packed {
    logic cfgLoWr;
    logic cfgHiWr;
    logic maskWr;
    logic pendClr;
  } eintStrobes_t;

  function automatic trigKind_t trigDecode(input logic [FIELD_W-1:0] code);
    case (code)
      3'b000:          return TRIG_LOW;
      3'b001:          return TRIG_HIGH;
      3'b010:          return TRIG_FALL;
      3'b100:          return TRIG_RISE;
      3'b110, 3'b111:  return TRIG_BOTH;
      default:         return TRIG_OFF;
    endcase
  endfunction

  function automatic logic [NUM_LINES-1:0] grpMask(input int g);
    logic [NUM_LINES-1:0] m;
    int lo, hi;
    lo = (g == 0) ? 0 : FIRST_GRP + (g - 1) * GRP_W;
    hi = FIRST_GRP + g * GRP_W - 1;
    for (int i = 0; i < NUM_LINES; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

endpackage

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   regSel,
  input  logic         regWr,
  output eintStrobes_t stb
);

  always_comb begin
    stb = '0;
    if (regWr) begin
      case (regSel)
        2'd0: stb.cfgLoWr = 1'b1;
        2'd1: stb.cfgHiWr = 1'b1;
        2'd2: stb.maskWr  = 1'b1;
        default: stb.pendClr = 1'b1;
      endcase
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/eint_line_detect.sv
module eint_line_detect
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rawIn,
  input  trigKind_t mode,
  output logic      hit
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign cur = syncQ[SYNC_STAGES-1];

  always_comb begin
    case (mode)
      TRIG_LOW:  hit = !cur;
      TRIG_HIGH: hit = cur;
      TRIG_FALL: hit = prevQ && !cur;
      TRIG_RISE: hit = !prevQ && cur;
      TRIG_BOTH: hit = prevQ ^ cur;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  eintStrobes_t         stb,
  input  logic [1:0]           regSel,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [NUM_LINES-1:0] extLines,
  output logic [DATA_W-1:0]    regRdata,
  output logic [NUM_GROUPS-1:0] grpIrq
);

  logic [FIELD_W-1:0]   cfgQ [NUM_PAIRS];
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] setVec;
  logic [NUM_LINES-1:0] clrVec;
  logic [NUM_LINES-1:0] liveVec;
  logic [DATA_W-1:0]    cfgLoView;
  logic [DATA_W-1:0]    cfgHiView;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit IN_LO = (p < PAIRS_PER_REG);
    localparam int NIB   = IN_LO ? p : p - PAIRS_PER_REG;
    logic wrHere;
    assign wrHere = IN_LO ? stb.cfgLoWr : stb.cfgHiWr;
    always_ff @(posedge clk) begin
      if (!rstN) cfgQ[p] <= '0;
      else if (wrHere) cfgQ[p] <= regWdata[NIB*STRIDE +: FIELD_W];
    end
  end

  for (genvar k = 0; k < PAIRS_PER_REG; k++) begin : g_view
    assign cfgLoView[k*STRIDE +: STRIDE] = {1'b0, cfgQ[k]};
    if (PAIRS_PER_REG + k < NUM_PAIRS) begin : g_hi
      assign cfgHiView[k*STRIDE +: STRIDE] = {1'b0, cfgQ[PAIRS_PER_REG + k]};
    end else begin : g_none
      assign cfgHiView[k*STRIDE +: STRIDE] = '0;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    eint_line_detect #(.SYNC_STAGES(2)) i_det (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (extLines[n]),
      .mode  (trigDecode(cfgQ[n/2])),
      .hit   (setVec[n])
    );
  end

  assign clrVec = stb.pendClr ? regWdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
      pendQ <= '0;
    end else begin
      if (stb.maskWr) maskQ <= regWdata[NUM_LINES-1:0];
      pendQ <= (pendQ & ~clrVec) | setVec;
    end
  end

  assign liveVec = pendQ & ~maskQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [NUM_LINES-1:0] GM = grpMask(g);
    assign grpIrq[g] = |(liveVec & GM);
  end

  always_comb begin
    case (regSel)
      2'd0:    regRdata = cfgLoView;
      2'd1:    regRdata = cfgHiView;
      2'd2:    regRdata = {{(DATA_W-NUM_LINES){1'b0}}, maskQ};
      default: regRdata = {{(DATA_W-NUM_LINES){1'b0}}, pendQ};
    endcase
  end

  // R7
  pend_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pendQ) & ~pendQ)) |-> $past(stb.pendClr));

  // R7
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendClr |=> ((pendQ & $past(regWdata[NUM_LINES-1:0]) & ~$past(setVec)) == '0));

  // R6
  mask_all_quiets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskWr && (&regWdata[NUM_LINES-1:0])) |=> (grpIrq == '0));

  // R6
  mask_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.maskWr |=> $stable(maskQ));

endmodule

// File: rtl/ext_irq_grouped.sv
module ext_irq_grouped
  import eint_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [27:0]  extLines,
  input  logic [1:0]   regSel,
  input  logic         regWr,
  input  logic [31:0]  regWdata,
  output logic [31:0]  regRdata,
  output logic [3:0]   grpIrq
);

  eintStrobes_t stb;

  eint_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .regWr  (regWr),
    .stb    (stb)
  );

  eint_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSel   (regSel),
    .regWdata (regWdata),
    .extLines (extLines),
    .regRdata (regRdata),
    .grpIrq   (grpIrq)
  );

endmodule

// File: tb/test_ext_irq_grouped.sv
module test_ext_irq_grouped;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] extLines = '0;
  logic [1:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  grpIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isGrp;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #5 clk = ~clk;

  ext_irq_grouped i_ext_irq_grouped (
    .clk(clk), .rstN(rstN), .extLines(extLines), .regSel(regSel),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .grpIrq(grpIrq)
  );

  // Monitor: compares queued expectations just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = it.isGrp ? {28'b0, grpIrq} : regRdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic pushReg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    expItem_t it;
    regSel = sel;
    it.isGrp = 1'b0; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic pushGrp(input logic [3:0] exp, input string tag);
    expItem_t it;
    it.isGrp = 1'b1; it.exp = {28'b0, exp}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chkReg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    pushReg(sel, exp, tag);
    @(negedge clk);
  endtask

  task automatic chkBoth(input logic [31:0] pend, input logic [3:0] grp, input string tag);
    @(negedge clk);
    pushReg(2'd3, pend, tag);
    pushGrp(grp, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setLine(input int idx, input logic v);
    @(negedge clk);
    extLines[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset values, checked while reset is held
    chkReg(2'd0, 32'h0, "R1 cfg lo");
    chkReg(2'd1, 32'h0, "R1 cfg hi");
    chkReg(2'd2, 32'h0FFFFFFF, "R1 mask");
    chkBoth(32'h0, 4'h0, "R1 pending/groups");
    @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R3 code 000 is low level: all inputs are low, all pending set; masked so no groups
    chkBoth(32'h0FFFFFFF, 4'h0, "R3 low level / R6 masked pending visible");
    // disable every pair, then clear
    wr(2'd0, 32'h33333333);
    wr(2'd1, 32'hFF333333);
    chkReg(2'd1, 32'h00333333, "R9 cfg hi upper byte");
    wr(2'd3, 32'hFFFFFFFF);
    repeat (3) @(negedge clk);
    chkReg(2'd3, 32'h0, "R7 clear all");
    // final configuration
    wr(2'd0, 32'h36133214);
    wr(2'd1, 32'hFFBBBF9B);
    chkReg(2'd0, 32'h36133214, "R2 cfg lo readback");
    chkReg(2'd1, 32'h00333713, "R2 nibble bit3 / R9");
    wr(2'd2, 32'hF0000000);
    chkReg(2'd2, 32'h0, "R9 mask upper");
    // R5 rising on shared pair 0
    setLine(0, 1'b1);
    chkBoth(32'h1, 4'h1, "R5 rise line0 / R8 g0");
    setLine(1, 1'b1);
    chkBoth(32'h3, 4'h1, "R2 shared field line1");
    wr(2'd3, 32'h3);
    chkBoth(32'h0, 4'h0, "R7 clear pair");
    setLine(0, 1'b0);
    setLine(1, 1'b0);
    chkBoth(32'h0, 4'h0, "R5 falling ignored in rise mode");
    // R3 disabled code 011 on line 6
    setLine(6, 1'b1);
    setLine(6, 1'b0);
    chkReg(2'd3, 32'h0, "R3 disabled code");
    // falling on line 4
    setLine(4, 1'b1);
    chkBoth(32'h0, 4'h0, "R5 rise ignored in fall mode");
    setLine(4, 1'b0);
    chkBoth(32'h10, 4'h2, "R5 fall line4 / R8 g1");
    wr(2'd3, 32'h0);
    chkReg(2'd3, 32'h10, "R7 write zero keeps");
    wr(2'd3, 32'hF0000010);
    chkReg(2'd3, 32'h0, "R7 clear line4 / R9");
    // either edge, line 20 (code 111) and line 12 (code 110)
    setLine(20, 1'b1);
    chkBoth(32'h00100000, 4'h8, "R3 both rise line20 / R8 g3");
    wr(2'd3, 32'h00100000);
    setLine(20, 1'b0);
    chkBoth(32'h00100000, 4'h8, "R3 both fall line20");
    wr(2'd3, 32'h00100000);
    setLine(12, 1'b1);
    chkBoth(32'h00001000, 4'h4, "R3 both code110 line12 / R8 g2");
    wr(2'd3, 32'h00001000);
    // R4 level high on line 11, clear while active
    setLine(11, 1'b1);
    chkBoth(32'h800, 4'h2, "R8 line11 in g1");
    wr(2'd3, 32'h800);
    chkReg(2'd3, 32'h800, "R4 clear while level active");
    setLine(11, 1'b0);
    wr(2'd3, 32'h800);
    chkReg(2'd3, 32'h0, "R4 clear after deassert");
    // R10 latency on line 3 (high level)
    @(negedge clk);
    extLines[3] = 1'b1;
    pushReg(2'd3, 32'h0, "R10 edge1");
    @(negedge clk);
    pushReg(2'd3, 32'h0, "R10 edge2");
    @(negedge clk);
    pushReg(2'd3, 32'h8, "R10 edge3");
    pushGrp(4'h1, "R8 line3 in g0");
    @(negedge clk);
    setLine(3, 1'b0);
    wr(2'd3, 32'h8);
    // R6 mask line 19
    wr(2'd2, 32'h00080000);
    setLine(19, 1'b1);
    chkBoth(32'h00080000, 4'h0, "R6 masked line19");
    wr(2'd2, 32'h0);
    chkBoth(32'h00080000, 4'h4, "R6 unmask / R8 line19 in g2");
    setLine(19, 1'b0);
    wr(2'd3, 32'h00080000);
    chkBoth(32'h0, 4'h0, "R7 final clear");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule